// File: doc/BRIEF.md
# SPI Register-Read Command Responder

This block is the read path of a serial control port. It acts as an SPI slave in mode 0. Its serial clock, chip-select and data input are brought into a faster system clock domain through a two-flop synchronizer. A transaction starts when chip-select falls. The block then shifts in one command byte. The top three bits of that byte are an operation code and the low five bits are a register address, both sent most significant bit first. If the operation code is the read code, the block fetches one byte from an external register file through a combinational read port and shifts it out on the serial output.

Each register belongs to one of two timing classes. The class is taken from a per-register lookup vector indexed by the current bank and the address. A register of the immediate class starts returning data right after the command byte, so the transaction is 16 clocks long. A register of the delayed class first returns one dummy byte of zeros, so the transaction is 24 clocks long. The output enable is low whenever the block is not driving the output. The read value is captured once, so it cannot change while it is being shifted out. Raising chip-select aborts the transaction at any point.

Top module: `spi_regrd_responder`

## Requirements
- R1: Out of reset, and within three system clocks after chip-select is seen high, `spi_miso_oe` is 0. Raising chip-select in the middle of a transaction aborts it, and the next transaction is decoded from its first bit.
- R2: An operation code other than 000 in bits 7..5 of the command byte keeps `spi_miso_oe` at 0 for the rest of the transaction, and `rd_req` never pulses.
- R3: Bits 4..0 of the command byte form the register address, sent MSB first. It appears on `rd_addr` while `rd_req` pulses, and `rd_req` pulses exactly once per read command, after the eighth rising SCK edge.
- R4: For an immediate-class register, the 8 data bits appear MSB first in bit slots 8..15 of the transaction. Bit slots are counted from 0, one slot per SCK rising edge.
- R5: For a delayed-class register (`slow_map[bank_sel*32+addr]` = 1), slots 8..15 carry a driven 0x00 dummy byte and slots 16..23 carry the data MSB first.
- R6: `spi_miso_oe` is 0 during slots 0..7 (operation code and address).
- R7: The outputs change only after a falling SCK edge, so they hold steady while SCK is high (mode 0).
- R8: The register value is captured in the cycle `rd_req` is high. Changes to `rd_data` after that cycle do not alter the shifted-out byte.
- R9: After the last data bit, `spi_miso_oe` drops at the next falling SCK edge and stays 0 if more clocks follow.
- R10: The class is chosen per bank, so the same address can be immediate in one bank and delayed in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out; 0 means high impedance |
| bank_sel | input | 2 | Currently selected register bank |
| slow_map | input | 128 | Class flag per register, index bank*32+address; 1 = dummy byte first |
| rd_addr | output | 5 | Address presented to the register file |
| rd_req | output | 1 | One-cycle read strobe; `rd_data` is captured in this cycle |
| rd_data | input | 8 | Combinational read data from the register file for the current bank |

## Verification
The embedded assertions check these properties on every cycle: the output is silent while a command is being received and after chip-select rises, the dummy byte stays low, the outputs change only after falling SCK edges, and each read strobe is a single pulse. The bench scenarios are the only place where actual bit-slot contents are compared against register values. They cover both classes across several banks, including an address whose class differs between banks, and boundary addresses 0 and 31. They also cover rejected operation codes, extra trailing clocks, a mid-command abort, and register contents that change after capture.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_DUMMY = 3'd2,
    ST_DATA  = 3'd3,
    ST_DONE  = 3'd4
  } rr_state_e;

  localparam logic [2:0] OPC_READ = 3'b000;

  // operation code sits in the top three bits of the command byte
  function automatic logic [2:0] opc_of(input logic [7:0] cmd);
    return cmd[7:5];
  endfunction

  // register address sits in the low five bits
  function automatic logic [4:0] addr_of(input logic [7:0] cmd);
    return cmd[4:0];
  endfunction

  // saturating increment for the bit counter
  function automatic logic [4:0] sat_inc(input logic [4:0] v);
    return (v == 5'd31) ? v : v + 5'd1;
  endfunction

endpackage

// File: rtl/spi_rr_sync.sv
module spi_rr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_rr_rx.sv
module spi_rr_rx #(
  parameter int CMD_W = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rise,
  input  logic             mosi,
  output logic [CMD_W-1:0] cmd_q,
  output logic             cmd_done,
  output logic [CNT_W-1:0] bit_cnt
);
  import spi_rr_pkg::*;

  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CMD_LEN  = CNT_W'(CMD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      cmd_done <= 1'b0;
      bit_cnt  <= '0;
    end else if (clr) begin
      cmd_q    <= '0;
      cmd_done <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (rise) begin
        bit_cnt <= sat_inc(bit_cnt);
        if (bit_cnt < CMD_LEN) begin
          cmd_q    <= {cmd_q[CMD_W-2:0], mosi};
          cmd_done <= (bit_cnt == LAST_CMD);
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done) else $error("command done not a pulse"); // R3

endmodule

// File: rtl/spi_rr_tx.sv
module spi_rr_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              send_zero,
  input  logic              send_data,
  input  logic              go_quiet,
  output logic              miso,
  output logic              oe,
  output logic              last_bit
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] data_q;
  logic [BIT_W-1:0]  obit;
  logic              shifting;

  assign shifting = send_zero | send_data;
  assign last_bit = fall && shifting && (obit == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      obit   <= '0;
      miso   <= 1'b0;
      oe     <= 1'b0;
    end else if (clr) begin
      data_q <= '0;
      obit   <= '0;
      miso   <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (load) begin
        data_q <= load_val;
        obit   <= '0;
      end
      if (fall) begin
        if (shifting) begin
          oe   <= 1'b1;
          obit <= obit + 1'b1;
          if (send_data) begin
            miso   <= data_q[DATA_W-1];
            data_q <= {data_q[DATA_W-2:0], 1'b0};
          end else begin
            miso <= 1'b0;
          end
        end else if (go_quiet) begin
          oe   <= 1'b0;
          miso <= 1'b0;
        end
      end
    end
  end

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(fall)) else $error("enable rose without SCK fall"); // R7

endmodule

// File: rtl/spi_regrd_responder.sv
module spi_regrd_responder #(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W = OPC_W + ADDR_W,
  localparam int MAP_W = (1 << BANK_W) * (1 << ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [MAP_W-1:0]  slow_map,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_req,
  input  logic [DATA_W-1:0] rd_data
);
  import spi_rr_pkg::*;

  // synchronized pins: {csn, sck, mosi}
  logic [2:0] pins_s;
  logic       csn_s, sck_s, mosi_s, sck_q;
  logic       sck_rise, sck_fall;

  spi_rr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_csn, spi_sck, spi_mosi}),
    .dout (pins_s)
  );
  assign {csn_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end
  assign sck_rise =  sck_s & ~sck_q;
  assign sck_fall = ~sck_s &  sck_q;

  // command receiver
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_done;
  logic [CNT_W-1:0] bit_cnt;

  spi_rr_rx #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (csn_s),
    .rise    (sck_rise),
    .mosi    (mosi_s),
    .cmd_q   (cmd_q),
    .cmd_done(cmd_done),
    .bit_cnt (bit_cnt)
  );

  logic [OPC_W-1:0]  cmd_opc;
  logic [ADDR_W-1:0] cmd_addr;
  logic              opc_is_read;
  logic              slow_hit;
  rr_state_e         state, state_nx;
  logic              last_bit;

  assign cmd_opc     = opc_of(cmd_q);
  assign cmd_addr    = addr_of(cmd_q);
  assign opc_is_read = (cmd_opc == OPC_READ);
  assign slow_hit    = slow_map[{bank_sel, cmd_addr}];

  assign rd_addr = cmd_addr;
  assign rd_req  = cmd_done && opc_is_read && (state == ST_CMD);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  state_nx = ST_CMD;
      ST_CMD:   if (cmd_done) state_nx = !opc_is_read ? ST_DONE :
                                         (slow_hit ? ST_DUMMY : ST_DATA);
      ST_DUMMY: if (last_bit) state_nx = ST_DATA;
      ST_DATA:  if (last_bit) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_DONE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= ST_IDLE;
    else if (csn_s) state <= ST_IDLE;
    else            state <= state_nx;
  end

  spi_rr_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (csn_s),
    .fall     (sck_fall),
    .load     (rd_req),
    .load_val (rd_data),
    .send_zero(state == ST_DUMMY),
    .send_data(state == ST_DATA),
    .go_quiet (state == ST_DONE),
    .miso     (spi_miso),
    .oe       (spi_miso_oe),
    .last_bit (last_bit)
  );

  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (state == ST_IDLE && !spi_miso_oe)) else $error("CS high not honoured"); // R1
  AST_BADOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !spi_miso_oe) |=> !spi_miso_oe) else $error("output after reject"); // R2
  AST_CMD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD) |-> (bit_cnt <= CNT_W'(CMD_W))) else $error("command overrun"); // R3
  AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMMY) |-> !spi_miso) else $error("dummy byte not zero"); // R5
  AST_HIZ_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_CMD) |-> !spi_miso_oe) else $error("driven during command"); // R6
  AST_HOLD_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !csn_s) |=> ($stable(spi_miso) && $stable(spi_miso_oe))) else $error("output moved without fall"); // R7
  AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req) else $error("read strobe too long"); // R8

endmodule

// File: tb/spi_regrd_responder_test.sv
`timescale 1ns/1ps
module spi_regrd_responder_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic         spi_miso, spi_miso_oe;
  logic [1:0]   bank_sel = 2'd0;
  logic [127:0] slow_map;
  logic [4:0]   rd_addr;
  logic         rd_req;
  logic [7:0]   rd_data;
  logic [7:0]   perturb = 8'h00;
  bit           perturb_arm = 1'b0;

  int checks = 0, fails = 0;
  int req_cnt = 0;
  logic [4:0] req_addr = '0;
  bit finished = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  event       sample_ev;

  always #4 clk = ~clk;

  function automatic logic [7:0] reg_val(input logic [1:0] b, input logic [4:0] a);
    return 8'((int'(a) * 37 + int'(b) * 91 + 3) & 8'hFF);
  endfunction

  function automatic bit is_slow(input logic [1:0] b, input logic [4:0] a);
    return (b[0] == 1'b0) ? (a >= 5'd24) : a[0];
  endfunction

  initial begin
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 32; a++)
        slow_map[b*32 + a] = is_slow(2'(b), 5'(a));
  end

  assign rd_data = reg_val(bank_sel, rd_addr) ^ perturb;

  spi_regrd_responder uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .bank_sel(bank_sel), .slow_map(slow_map), .rd_addr(rd_addr),
    .rd_req(rd_req), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (rd_req) begin
      req_cnt  <= req_cnt + 1;
      req_addr <= rd_addr;
      if (perturb_arm) perturb <= 8'hFF;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected slot per SCK rising edge
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() != 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " oe"}, {7'd0, spi_miso_oe}, {7'd0, e[1]});
        if (e[1]) check({t, " bit"}, {7'd0, spi_miso}, {7'd0, e[0]});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected slots, then clocks the transaction
  task automatic run_cmd(input logic [2:0] op, input logic [4:0] a, input int nclk);
    logic [7:0] cmd, val;
    bit slow, ok;
    int req0;
    cmd  = {op, a};
    val  = reg_val(bank_sel, a);
    slow = is_slow(bank_sel, a);
    ok   = (op == 3'b000);
    for (int i = 0; i < nclk; i++) begin
      int k;
      if (i < 8) begin
        exp_q.push_back(2'b00); tag_q.push_back("R6");
      end else if (!ok) begin
        exp_q.push_back(2'b00); tag_q.push_back("R2");
      end else if (slow && i < 16) begin
        exp_q.push_back(2'b10); tag_q.push_back("R5");
      end else if (slow && i < 24) begin
        k = i - 16;
        exp_q.push_back({1'b1, val[7-k]}); tag_q.push_back("R5");
      end else if (!slow && i < 16) begin
        k = i - 8;
        exp_q.push_back({1'b1, val[7-k]}); tag_q.push_back("R4");
      end else begin
        exp_q.push_back(2'b00); tag_q.push_back("R9");
      end
    end
    req0 = req_cnt;
    spi_csn = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nclk; i++) begin
      logic [1:0] held;
      spi_mosi = (i < 8) ? cmd[7-i] : 1'b0;
      wait_clk(8);
      -> sample_ev;
      held = {spi_miso_oe, spi_miso};
      spi_sck = 1'b1;
      wait_clk(7);
      check("R7 hold while SCK high", {6'd0, spi_miso_oe, spi_miso}, {6'd0, held});
      wait_clk(1);
      spi_sck = 1'b0;
    end
    wait_clk(8);
    spi_csn = 1'b1;
    wait_clk(6);
    check("R1 quiet after CS high", {7'd0, spi_miso_oe}, 8'd0);
    if (ok && nclk >= 8) begin
      check("R3 one strobe", 8'(req_cnt - req0), 8'd1);
      check("R3 address", {3'd0, req_addr}, {3'd0, a});
    end else begin
      check("R2 no strobe", 8'(req_cnt - req0), 8'd0);
    end
  endtask

  initial begin
    wait_clk(5);
    check("R1 reset oe", {7'd0, spi_miso_oe}, 8'd0);
    check("R1 reset strobe", {7'd0, rd_req}, 8'd0);
    rst_n = 1'b1;
    wait_clk(5);

    bank_sel = 2'd0; run_cmd(3'b000, 5'd5, 16);   // R4
    bank_sel = 2'd0; run_cmd(3'b000, 5'd26, 24);  // R5
    bank_sel = 2'd1; run_cmd(3'b000, 5'd26, 16);  // R10 same address, other bank: immediate
    bank_sel = 2'd1; run_cmd(3'b000, 5'd3, 24);   // R10 odd address delayed in bank 1
    bank_sel = 2'd2; run_cmd(3'b000, 5'd31, 24);  // R3 top address
    bank_sel = 2'd3; run_cmd(3'b000, 5'd0, 16);   // R3 bottom address
    bank_sel = 2'd0; run_cmd(3'b010, 5'd5, 24);   // R2
    bank_sel = 2'd0; run_cmd(3'b111, 5'd30, 24);  // R2
    bank_sel = 2'd2; run_cmd(3'b000, 5'd9, 22);   // R9 extra clocks, immediate
    bank_sel = 2'd0; run_cmd(3'b000, 5'd28, 30);  // R9 extra clocks, delayed

    // R1 abort after four command bits, then a clean read
    exp_q.delete(); tag_q.delete();
    for (int i = 0; i < 4; i++) begin exp_q.push_back(2'b00); tag_q.push_back("R1"); end
    spi_csn = 1'b0; wait_clk(4);
    for (int i = 0; i < 4; i++) begin
      spi_mosi = 1'b1; wait_clk(8); -> sample_ev; spi_sck = 1'b1; wait_clk(8); spi_sck = 1'b0;
    end
    wait_clk(4); spi_csn = 1'b1; wait_clk(6);
    check("R1 abort quiet", {7'd0, spi_miso_oe}, 8'd0);
    bank_sel = 2'd3; run_cmd(3'b000, 5'd14, 16);  // R1 recovery

    // R8 register changes after capture
    perturb_arm = 1'b1;
    bank_sel = 2'd0; run_cmd(3'b000, 5'd12, 16);  // R8 immediate
    perturb = 8'h00;
    bank_sel = 2'd2; run_cmd(3'b000, 5'd25, 24);  // R8 delayed
    perturb_arm = 1'b0;
    perturb = 8'h00;

    wait_clk(4);
    check("R4 queue drained", 8'(exp_q.size()), 8'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule